// File: doc/BRIEF.md
# Calibration Strobe Failure Mask

This block keeps one sticky failure flag for every data strobe pair on every rank: 18 strobes on each of 2 ranks, so 36 flags. While a receiver-enable gathering pass runs, the calibration engine reports a done pulse for each strobe it has finished. With each pulse it also says whether a usable strobe waveform was seen. A done pulse without a seen waveform raises the flag for that strobe on the rank under calibration. The flags then stay set until software clears them. Hardware never lowers a flag, even if a later pass finds a good waveform.

The flags also act as a filter on the calibration sample stream. During the gathering and analysis phases of the receiver-enable calibration and the strobe delay calibration, each sample is tagged with its rank and strobe. The block returns a registered keep/drop verdict one cycle later. Samples from a flagged strobe are dropped, so a broken strobe cannot bias the result for neighbouring strobes that share logic with it. Software reads the flags through two 32-bit words and clears them by writing ones.

Top module: `strobe_fail_mask`

## Requirements
- R1: After reset all 36 flags read 0, and keepValid and keepSample are 0.
- R2: When calPhase is 1 (receiver-enable gather) and strobeDone[s]=1 with strobeSeen[s]=0, the flag for rank calRank and strobe s is set, and it is visible on regRdData after the next rising edge.
- R3: A set flag stays set when a later done pulse for the same strobe arrives with strobeSeen=1.
- R4: Done pulses have no effect on the flags in any calPhase other than 1.
- R5: A write to word 0 or word 1 clears each flag whose bit in regWrData is 1. Bits written as 0 leave their flags unchanged.
- R6: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R7: Word layout. Word 0 bits 0..17 hold rank 0 strobes 0..17. Word 0 bits 18..24 hold rank 1 strobes 0..6, and bits 25..31 hold rank 1 strobes 9..15. Word 1 bit 0 holds rank 1 strobe 7, bit 1 holds strobe 16, bit 2 holds strobe 8 and bit 3 holds strobe 17. Word 1 bits 4..31 and addresses 2 and 3 read 0, and writes to them change nothing.
- R8: keepValid is sampleValid delayed by exactly one clock, and keepSample carries the verdict for that sample in the same cycle.
- R9: While calPhase is 1, 2, 3 or 4 (receiver-enable gather and analysis, delay gather and analysis), keepSample is the inverse of the flag of the addressed rank and strobe.
- R10: While calPhase is 0, 5, 6 or 7, every sample with an in-range strobe is kept (keepSample=1).
- R11: A sample with sampleStrobe of 18 or more is dropped (keepSample=0) in every phase.
- R12: The verdict uses the flag value held before the edge that registers it, so a flag set in the same cycle does not drop that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calPhase | input | 3 | Calibration phase code: 0 idle, 1 receiver-enable gather, 2 receiver-enable analysis, 3 delay gather, 4 delay analysis |
| calRank | input | 1 | Rank under calibration for the done pulses |
| strobeDone | input | 18 | Per-strobe detection-complete pulse |
| strobeSeen | input | 18 | Per-strobe valid waveform seen |
| regWrEn | input | 1 | Software write strobe (write-one-to-clear) |
| regAddr | input | 2 | Word select for read and write |
| regWrData | input | 32 | Write data; ones clear flags |
| regRdData | output | 32 | Read data of the selected word (combinational) |
| sampleValid | input | 1 | Calibration sample present |
| sampleRank | input | 1 | Rank of the sample |
| sampleStrobe | input | 5 | Strobe index of the sample |
| keepValid | output | 1 | Verdict valid, one cycle after sampleValid |
| keepSample | output | 1 | 1 keeps the sample, 0 drops it |

## Verification
Two collisions can occur in a single cycle. A hardware set and a software write-one-to-clear can hit the same flag, and a flag can be set in the same cycle that a sample of that strobe is filtered. Directed cycles drive a failing done pulse, a clearing write and a sample for the same strobe together. The test then expects the flag to survive and the sample to be kept. Random cycles create these overlaps by chance against a bench model that applies the clear first, the set second, and the verdict from the old flags.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int RANKS    = 2;
  localparam int STROBES  = 18;
  localparam int FLAGS    = RANKS * STROBES;
  localparam int REGW     = 32;
  localparam int NREGS    = (FLAGS + REGW - 1) / REGW;
  localparam int RANKW    = (RANKS > 1) ? $clog2(RANKS) : 1;
  localparam int STRW     = 5;
  localparam int ADDRW    = 2;
  localparam int FLAGIDXW = $clog2(FLAGS) + 1;
  localparam int PHW      = 3;

  typedef enum logic [PHW-1:0] {
    PH_IDLE        = 3'd0,
    PH_RE_GATHER   = 3'd1,
    PH_RE_ANALYZE  = 3'd2,
    PH_DLY_GATHER  = 3'd3,
    PH_DLY_ANALYZE = 3'd4
  } calPhase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [FLAGS-1:0]    setMask;
    logic [FLAGS-1:0]    clrMask;
    logic                sampleGo;
    logic                idxOk;
    logic                maskOn;
    logic [FLAGIDXW-1:0] sampleFlag;
  } ctrlStrobe_t;

  // Rank 1 strobes that live in the second word, in bit order
  function automatic bit isHighStrobe(int unsigned s);
    return (s == 7) || (s == 16) || (s == 8) || (s == 17);
  endfunction

  // Word that holds flat flag f (f = rank*STROBES + strobe)
  function automatic int unsigned flagReg(int unsigned f);
    int unsigned r;
    int unsigned s;
    r = f / STROBES;
    s = f % STROBES;
    if (r == 1 && isHighStrobe(s)) return 1;
    return 0;
  endfunction

  // Bit position of flat flag f inside its word
  function automatic int unsigned flagBit(int unsigned f);
    int unsigned r;
    int unsigned s;
    r = f / STROBES;
    s = f % STROBES;
    if (r == 0) return s;
    case (s)
      7:  return 0;
      16: return 1;
      8:  return 2;
      17: return 3;
      default: return (s < 7) ? (STROBES + s) : (STROBES + s - 2);
    endcase
  endfunction

endpackage

// File: rtl/sfm_ctrl.sv
module sfm_ctrl
  import sfm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PHW-1:0]   calPhase,
  input  logic [RANKW-1:0] calRank,
  input  logic [STROBES-1:0] strobeDone,
  input  logic [STROBES-1:0] strobeSeen,
  input  logic             regWrEn,
  input  logic [ADDRW-1:0] regAddr,
  input  logic [REGW-1:0]  regWrData,
  input  logic             sampleValid,
  input  logic [RANKW-1:0] sampleRank,
  input  logic [STRW-1:0]  sampleStrobe,
  output ctrlStrobe_t      ctl
);

  logic reGather;
  logic maskPhase;

  assign reGather  = (calPhase == PH_RE_GATHER);
  assign maskPhase = (calPhase == PH_RE_GATHER)  || (calPhase == PH_RE_ANALYZE) ||
                     (calPhase == PH_DLY_GATHER) || (calPhase == PH_DLY_ANALYZE);

  // Hardware set requests: failed detection during receiver-enable gather
  for (genvar r = 0; r < RANKS; r++) begin : gSetRank
    for (genvar s = 0; s < STROBES; s++) begin : gSetStrobe
      assign ctl.setMask[r*STROBES + s] = reGather && (calRank == RANKW'(r)) &&
                                          strobeDone[s] && !strobeSeen[s];
    end
  end

  // Software clear requests: write one to clear, mapped per flag
  for (genvar f = 0; f < FLAGS; f++) begin : gClr
    localparam int unsigned WordSel = flagReg(f);
    localparam int unsigned BitSel  = flagBit(f);
    assign ctl.clrMask[f] = regWrEn && (regAddr == ADDRW'(WordSel)) && regWrData[BitSel];
  end

  // Sample addressing
  logic strobeInRange;
  assign strobeInRange  = ({1'b0, sampleStrobe} < (STRW+1)'(STROBES));
  assign ctl.sampleGo   = sampleValid;
  assign ctl.idxOk      = strobeInRange;
  assign ctl.maskOn     = maskPhase;
  assign ctl.sampleFlag = strobeInRange ?
      (FLAGIDXW'(sampleRank) * FLAGIDXW'(STROBES) + FLAGIDXW'(sampleStrobe)) : '0;

  AST_SET_ONLY_RE_GATHER: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setMask != '0) |-> (calPhase == PH_RE_GATHER)) else $error("set outside gather"); // R4

  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrMask != '0) |-> (regWrEn && regAddr < ADDRW'(NREGS))) else $error("stray clear"); // R5

endmodule

// File: rtl/sfm_data.sv
module sfm_data
  import sfm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctl,
  input  logic [ADDRW-1:0] regAddr,
  output logic [REGW-1:0]  regRdData,
  output logic             keepValid,
  output logic             keepSample
);

  logic [FLAGS-1:0] flagQ;
  logic [FLAGS-1:0] flagNext;
  logic             keepValidQ;
  logic             keepQ;
  logic             verdict;
  logic [REGW-1:0]  wordImg [NREGS];

  // Clear first, then set: a same-cycle set survives the clear
  assign flagNext = (flagQ & ~ctl.clrMask) | ctl.setMask;

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNext;
  end

  // Verdict from the flags held before this edge
  always_comb begin
    if (!ctl.idxOk)       verdict = 1'b0;
    else if (!ctl.maskOn) verdict = 1'b1;
    else                  verdict = !flagQ[ctl.sampleFlag];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keepValidQ <= 1'b0;
      keepQ      <= 1'b0;
    end else begin
      keepValidQ <= ctl.sampleGo;
      keepQ      <= ctl.sampleGo && verdict;
    end
  end

  assign keepValid  = keepValidQ;
  assign keepSample = keepQ;

  // Software view of the flags
  always_comb begin
    for (int w = 0; w < NREGS; w++) wordImg[w] = '0;
    for (int f = 0; f < FLAGS; f++) wordImg[flagReg(f)][flagBit(f)] = flagQ[f];
  end

  always_comb begin
    regRdData = '0;
    for (int w = 0; w < NREGS; w++)
      if (regAddr == ADDRW'(w)) regRdData = wordImg[w];
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & ~ctl.clrMask) != '0) |=> (($past(flagQ) & ~$past(ctl.clrMask) & ~flagQ) == '0))
    else $error("flag dropped without clear"); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setMask != '0) |=> ((flagQ & $past(ctl.setMask)) == $past(ctl.setMask)))
    else $error("set lost"); // R6

  AST_KEEP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sampleGo |=> keepValid) else $error("verdict missing"); // R8

  AST_BAD_INDEX_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sampleGo && !ctl.idxOk) |=> (keepValid && !keepSample))
    else $error("out of range sample kept"); // R11

  AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.sampleGo |=> !keepSample) else $error("keep without sample"); // R8

endmodule

// File: rtl/strobe_fail_mask.sv
module strobe_fail_mask
  import sfm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PHW-1:0]      calPhase,
  input  logic [RANKW-1:0]    calRank,
  input  logic [STROBES-1:0]  strobeDone,
  input  logic [STROBES-1:0]  strobeSeen,
  input  logic                regWrEn,
  input  logic [ADDRW-1:0]    regAddr,
  input  logic [REGW-1:0]     regWrData,
  output logic [REGW-1:0]     regRdData,
  input  logic                sampleValid,
  input  logic [RANKW-1:0]    sampleRank,
  input  logic [STRW-1:0]     sampleStrobe,
  output logic                keepValid,
  output logic                keepSample
);

  ctrlStrobe_t ctl;

  sfm_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .calPhase     (calPhase),
    .calRank      (calRank),
    .strobeDone   (strobeDone),
    .strobeSeen   (strobeSeen),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .sampleValid  (sampleValid),
    .sampleRank   (sampleRank),
    .sampleStrobe (sampleStrobe),
    .ctl          (ctl)
  );

  sfm_data uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .regAddr    (regAddr),
    .regRdData  (regRdData),
    .keepValid  (keepValid),
    .keepSample (keepSample)
  );

endmodule

// File: tb/tb_strobe_fail_mask.sv
module tb_strobe_fail_mask;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  calPhase;
  logic        calRank;
  logic [17:0] strobeDone;
  logic [17:0] strobeSeen;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        sampleValid;
  logic        sampleRank;
  logic [4:0]  sampleStrobe;
  logic        keepValid;
  logic        keepSample;

  int checks = 0;
  int errors = 0;
  logic [35:0] mdl;

  always #5 clk = ~clk;

  strobe_fail_mask dut (
    .clk(clk), .rstN(rstN), .calPhase(calPhase), .calRank(calRank),
    .strobeDone(strobeDone), .strobeSeen(strobeSeen), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sampleValid(sampleValid), .sampleRank(sampleRank), .sampleStrobe(sampleStrobe),
    .keepValid(keepValid), .keepSample(keepSample)
  );

  // Word and bit of flag (rank, strobe), as laid down in R7
  function automatic int wordOf(int r, int s);
    if (r == 1 && (s == 7 || s == 16 || s == 8 || s == 17)) return 1;
    return 0;
  endfunction

  function automatic int bitOf(int r, int s);
    if (r == 0) return s;
    if (s == 7)  return 0;
    if (s == 16) return 1;
    if (s == 8)  return 2;
    if (s == 17) return 3;
    if (s <= 6)  return 18 + s;
    return 25 + (s - 9);
  endfunction

  function automatic logic [31:0] expWord(int a);
    logic [31:0] v = '0;
    for (int f = 0; f < 36; f++)
      if (mdl[f] && wordOf(f / 18, f % 18) == a) v[bitOf(f / 18, f % 18)] = 1'b1;
    return v;
  endfunction

  function automatic logic expKeep(int ph, int r, int s);
    if (s >= 18) return 1'b0;
    if (ph >= 1 && ph <= 4) return !mdl[r*18 + s];
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    calPhase = 3'd0; calRank = 1'b0; strobeDone = '0; strobeSeen = '0;
    regWrEn = 1'b0; regAddr = 2'd0; regWrData = '0;
    sampleValid = 1'b0; sampleRank = 1'b0; sampleStrobe = '0;
  endtask

  // One clock of stimulus, applied just after a falling edge
  task automatic doCycle(string tag, int ph, int rk, logic [17:0] dn, logic [17:0] sn,
                         logic we, int ad, logic [31:0] wd, logic sv, int sr, int ss);
    logic [35:0] setV = '0;
    logic [35:0] clrV = '0;
    logic        ek;
    calPhase = 3'(ph); calRank = rk[0]; strobeDone = dn; strobeSeen = sn;
    regWrEn = we; regAddr = 2'(ad); regWrData = wd;
    sampleValid = sv; sampleRank = sr[0]; sampleStrobe = 5'(ss);
    ek = sv && expKeep(ph, sr, ss);
    for (int s = 0; s < 18; s++)
      if (ph == 1 && dn[s] && !sn[s]) setV[rk*18 + s] = 1'b1;
    for (int f = 0; f < 36; f++)
      if (we && ad < 2 && wordOf(f / 18, f % 18) == ad && wd[bitOf(f / 18, f % 18)])
        clrV[f] = 1'b1;
    @(posedge clk);
    mdl = (mdl & ~clrV) | setV;
    @(negedge clk);
    idleInputs();
    chk({tag, " keepValid"}, 32'(keepValid), 32'(sv));
    chk({tag, " keepSample"}, 32'(keepSample), 32'(ek));
  endtask

  task automatic readCheck(string tag, int a);
    regAddr = 2'(a);
    #1;
    chk({tag, " read"}, regRdData, expWord(a));
    regAddr = 2'd0;
  endtask

  task automatic readAll(string tag);
    for (int a = 0; a < 4; a++) readCheck(tag, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    idleInputs();
    mdl = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 keepValid", 32'(keepValid), 32'd0);
    chk("R1 keepSample", 32'(keepSample), 32'd0);
    readAll("R1");

    // R2 failed detection sets rank 0 strobe 3
    doCycle("R2", 1, 0, 18'h8, 18'h0, 0, 0, 0, 0, 0, 0);
    readAll("R2");

    // R7 layout: rank 1 high strobes, one at a time, and word 0 edges
    doCycle("R7 s7", 1, 1, 18'(1 << 7), 18'h0, 0, 0, 0, 0, 0, 0);
    readCheck("R7 s7", 1);
    doCycle("R7 s16", 1, 1, 18'(1 << 16), 18'h0, 0, 0, 0, 0, 0, 0);
    readCheck("R7 s16", 1);
    doCycle("R7 s8s17", 1, 1, 18'(1 << 8) | 18'(1 << 17), 18'h0, 0, 0, 0, 0, 0, 0);
    readAll("R7 s8s17");
    doCycle("R7 r1s0s15", 1, 1, 18'h1 | 18'(1 << 15), 18'h0, 0, 0, 0, 0, 0, 0);
    readCheck("R7 r1s0s15", 0);

    // R3 a good waveform later does not clear
    doCycle("R3", 1, 0, 18'h8, 18'h8, 0, 0, 0, 0, 0, 0);
    readCheck("R3", 0);

    // R4 done pulses outside receiver-enable gather are ignored
    for (int ph = 0; ph < 8; ph++)
      if (ph != 1) doCycle("R4", ph, 0, 18'h3FFF0, 18'h0, 0, 0, 0, 0, 0, 0);
    readAll("R4");

    // R9 masking in each gather and analysis phase
    for (int ph = 1; ph <= 4; ph++) begin
      doCycle("R9 bad", ph, 0, 0, 0, 0, 0, 0, 1, 0, 3);
      doCycle("R9 good", ph, 0, 0, 0, 0, 0, 0, 1, 0, 4);
      doCycle("R9 r1", ph, 0, 0, 0, 0, 0, 0, 1, 1, 17);
    end

    // R10 no masking when idle
    doCycle("R10", 0, 0, 0, 0, 0, 0, 0, 1, 0, 3);
    doCycle("R10 ph6", 6, 0, 0, 0, 0, 0, 0, 1, 1, 7);

    // R11 out-of-range strobe dropped
    doCycle("R11", 0, 0, 0, 0, 0, 0, 0, 1, 0, 20);
    doCycle("R11 ph2", 2, 0, 0, 0, 0, 0, 0, 1, 1, 18);

    // R5 zeros do nothing, ones clear
    doCycle("R5 zero", 0, 0, 0, 0, 1, 0, 32'h0, 0, 0, 0);
    readAll("R5 zero");
    doCycle("R5 one", 0, 0, 0, 0, 1, 1, 32'h2, 0, 0, 0);
    readAll("R5 one");

    // R7 reserved bits and unused addresses
    doCycle("R7 rsv", 0, 0, 0, 0, 1, 1, 32'hFFFF_FFF0, 0, 0, 0);
    doCycle("R7 addr2", 0, 0, 0, 0, 1, 2, 32'hFFFF_FFFF, 0, 0, 0);
    doCycle("R7 addr3", 0, 0, 0, 0, 1, 3, 32'hFFFF_FFFF, 0, 0, 0);
    readAll("R7 rsv");

    // R6 and R12: set, clear and sample of rank 0 strobe 5 in one cycle
    doCycle("R6 R12", 1, 0, 18'h20, 18'h0, 1, 0, 32'h20, 1, 0, 5);
    readAll("R6");
    doCycle("R12 after", 2, 0, 0, 0, 0, 0, 0, 1, 0, 5);

    // Clear everything, then random traffic
    doCycle("R5 all0", 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    doCycle("R5 all1", 0, 0, 0, 0, 1, 1, 32'hF, 0, 0, 0);
    readAll("R5 all");

    for (int i = 0; i < 600; i++) begin
      int ph;
      logic [17:0] dn;
      ph = ($urandom % 3 == 0) ? 1 : int'($urandom % 8);
      dn = 18'($urandom) & 18'($urandom) & 18'($urandom);
      doCycle("RND R2 R5 R6 R9", ph, int'($urandom % 2), dn, 18'($urandom),
              ($urandom % 4 == 0), int'($urandom % 4), $urandom & $urandom,
              ($urandom % 4 != 0), int'($urandom % 2), int'($urandom % 20));
      readCheck("RND R7", int'($urandom % 4));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule